// File: doc/BRIEF.md
# Reset-Configured Width Matcher with Selectable Byte Order

This block sits between the write side and the read side of a queue and reconciles their widths. Each side is either a long word (two bytes) or a single byte wide. The byte is 9 bits by default, so a long word is 18 bits. When a long word enters and the reader takes bytes, every word leaves as two consecutive bytes. When bytes enter and the reader takes long words, every two consecutive bytes are joined into one word. When both sides have the same width, the data goes straight through.

The two width selects and the byte-order select are sampled only while the active-low master reset is held. They are ignored afterwards. Byte order decides which half of a long word goes with the first byte of a pair, for splitting and for packing alike. Both sides use a valid/ready handshake, and everything runs on a single clock.

Top module: `bus_width_matcher`

## Requirements
- R1: While `rst_n` is low the block captures `{cfg_wr_narrow, cfg_rd_narrow}`. The codes are 00 long→long, 01 long→byte (split), 10 byte→long (pack) and 11 byte→byte. It also captures `cfg_big_n`, where 0 means big-endian and 1 means little-endian. Changes on these three pins after reset have no effect on the data path.
- R2: In long→long mode, `out_valid` follows `in_valid`, `in_ready` follows `out_ready`, and `out_data` equals `in_data` on all 18 bits in the same cycle.
- R3: In byte→byte mode, the byte in `in_data[8:0]` passes to `out_data[8:0]` in the same cycle, and `out_data[17:9]` is zero.
- R4: In split mode with big-endian order, a word is delivered as bits [17:9] first and then bits [8:0]. Each byte appears on `out_data[8:0]` with `out_data[17:9]` zero.
- R5: In split mode with little-endian order, a word is delivered as bits [8:0] first and then bits [17:9].
- R6: In pack mode with big-endian order, the first byte of a pair goes into `out_data[17:9]` and the second goes into `out_data[8:0]`.
- R7: In pack mode with little-endian order, the first byte goes into `out_data[8:0]` and the second goes into `out_data[17:9]`.
- R8: In split and pack modes, `out_valid` and `out_data` stay stable while `out_valid` is high and `out_ready` is low.
- R9: A byte accepted in pack mode whose partner has not yet arrived is discarded by master reset. The next two bytes form the next word.
- R10: After reset in split or pack mode, `out_valid` is 0 and `in_ready` is 1.
- R11: In split mode, the first byte of an accepted word is valid in the cycle after the accepting edge. `in_ready` stays low until that word's second byte is being taken.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low master reset; configuration is sampled while it is low |
| cfg_wr_narrow | input | 1 | 1 = write side is one byte wide |
| cfg_rd_narrow | input | 1 | 1 = read side is one byte wide |
| cfg_big_n | input | 1 | 0 = big-endian byte order, 1 = little-endian |
| in_valid | input | 1 | Write-side data valid |
| in_ready | output | 1 | Write-side data accepted when high with `in_valid` |
| in_data | input | 18 | Write data; a byte occupies bits [8:0] |
| out_valid | output | 1 | Read-side data valid |
| out_ready | input | 1 | Reader takes data when high with `out_valid` |
| out_data | output | 18 | Read data; a byte occupies bits [8:0] |

## Verification
The same-width paths have no register, so the bench checks R2 and R3 a moment after driving the inputs, inside the same clock low phase. In split mode the first byte is due one cycle after the accepting edge, and the second byte is due after the edge that takes the first. The pack word is due one cycle after the edge that accepts the second byte. The bench drives inputs on falling edges and reads results before the next rising edge. It waits on `out_valid` and `in_ready` rather than assuming a fixed count, and checks R11 at the exact cycle.

// File: rtl/bwm_pkg.sv
package bwm_pkg;
   typedef enum logic [1:0] {
      MODE_LONG_LONG = 2'b00,
      MODE_SPLIT     = 2'b01,
      MODE_PACK      = 2'b10,
      MODE_BYTE_BYTE = 2'b11
   } bwm_mode_e;
endpackage

// File: rtl/bwm_mode_latch.sv
module bwm_mode_latch
   import bwm_pkg::*;
(
   input  logic      clk,
   input  logic      rst_n,
   input  logic      cfg_wr_narrow,
   input  logic      cfg_rd_narrow,
   input  logic      cfg_big_n,
   output bwm_mode_e mode,
   output logic      big
);
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         mode <= bwm_mode_e'({cfg_wr_narrow, cfg_rd_narrow});
         big  <= ~cfg_big_n;
      end
   end

   // R1: configuration frozen once reset is released
   assert_mode_frozen_R1: assert property (@(posedge clk) disable iff (!rst_n)
      rst_n |=> ($stable(mode) && $stable(big)));
endmodule

// File: rtl/bwm_split.sv
module bwm_split #(
   parameter int BYTE_W = 9
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              big,
   input  logic              in_valid,
   output logic              in_ready,
   input  logic [2*BYTE_W-1:0] in_word,
   output logic              out_valid,
   input  logic              out_ready,
   output logic [BYTE_W-1:0] out_byte
);
   localparam int WORD_W = 2 * BYTE_W;

   logic              hold_vld;
   logic              phase;
   logic [WORD_W-1:0] word;
   logic [BYTE_W-1:0] hi_b, lo_b;
   logic              take_in, take_out;

   assign hi_b      = word[WORD_W-1:BYTE_W];
   assign lo_b      = word[BYTE_W-1:0];
   assign out_valid = hold_vld;
   assign out_byte  = (big ^ phase) ? hi_b : lo_b;
   assign in_ready  = !hold_vld || (phase && out_ready);
   assign take_in   = in_valid && in_ready;
   assign take_out  = out_valid && out_ready;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         hold_vld <= 1'b0;
         phase    <= 1'b0;
         word     <= '0;
      end else if (take_in) begin
         word     <= in_word;
         hold_vld <= 1'b1;
         phase    <= 1'b0;
      end else if (take_out) begin
         if (phase) hold_vld <= 1'b0;
         else       phase    <= 1'b1;
      end
   end

   // R8: stalled byte does not move
   assert_split_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && !out_ready) |=> (out_valid && $stable(out_byte)));
   // R11: accepted word yields a byte next cycle and blocks the input
   assert_split_load_R11: assert property (@(posedge clk) disable iff (!rst_n)
      take_in |=> (out_valid && !in_ready));
endmodule

// File: rtl/bwm_pack.sv
module bwm_pack #(
   parameter int BYTE_W = 9
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                big,
   input  logic                in_valid,
   output logic                in_ready,
   input  logic [BYTE_W-1:0]   in_byte,
   output logic                out_valid,
   input  logic                out_ready,
   output logic [2*BYTE_W-1:0] out_word
);
   localparam int WORD_W = 2 * BYTE_W;

   logic              have_first;
   logic [BYTE_W-1:0] first_b;
   logic              full;
   logic [WORD_W-1:0] word;
   logic              take_in, take_out;

   assign out_valid = full;
   assign out_word  = word;
   assign in_ready  = !full || out_ready;
   assign take_in   = in_valid && in_ready;
   assign take_out  = out_valid && out_ready;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         have_first <= 1'b0;
         first_b    <= '0;
         full       <= 1'b0;
         word       <= '0;
      end else begin
         if (take_out) full <= 1'b0;
         if (take_in) begin
            if (!have_first) begin
               first_b    <= in_byte;
               have_first <= 1'b1;
            end else begin
               word       <= big ? {first_b, in_byte} : {in_byte, first_b};
               full       <= 1'b1;
               have_first <= 1'b0;
            end
         end
      end
   end

   // R8: stalled word does not move
   assert_pack_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && !out_ready) |=> (out_valid && $stable(out_word)));
   // R6: second byte of a pair completes a word
   assert_pack_pair_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (take_in && have_first) |=> out_valid);
endmodule

// File: rtl/bus_width_matcher.sv
module bus_width_matcher
   import bwm_pkg::*;
#(
   parameter int BYTE_W = 9,
   localparam int WORD_W = 2 * BYTE_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cfg_wr_narrow,
   input  logic              cfg_rd_narrow,
   input  logic              cfg_big_n,
   input  logic              in_valid,
   output logic              in_ready,
   input  logic [WORD_W-1:0] in_data,
   output logic              out_valid,
   input  logic              out_ready,
   output logic [WORD_W-1:0] out_data
);
   if (BYTE_W < 1) begin : g_bad_width
      $error("bus_width_matcher: BYTE_W must be at least 1");
   end

   bwm_mode_e mode;
   logic      big;
   logic      sp_en, pk_en;
   logic      sp_in_ready, sp_out_valid;
   logic [BYTE_W-1:0] sp_byte;
   logic      pk_in_ready, pk_out_valid;
   logic [WORD_W-1:0] pk_word;

   bwm_mode_latch u_mode (
      .clk(clk), .rst_n(rst_n),
      .cfg_wr_narrow(cfg_wr_narrow), .cfg_rd_narrow(cfg_rd_narrow),
      .cfg_big_n(cfg_big_n), .mode(mode), .big(big)
   );

   assign sp_en = (mode == MODE_SPLIT);
   assign pk_en = (mode == MODE_PACK);

   bwm_split #(.BYTE_W(BYTE_W)) u_split (
      .clk(clk), .rst_n(rst_n), .big(big),
      .in_valid(in_valid && sp_en), .in_ready(sp_in_ready), .in_word(in_data),
      .out_valid(sp_out_valid), .out_ready(out_ready && sp_en), .out_byte(sp_byte)
   );

   bwm_pack #(.BYTE_W(BYTE_W)) u_pack (
      .clk(clk), .rst_n(rst_n), .big(big),
      .in_valid(in_valid && pk_en), .in_ready(pk_in_ready), .in_byte(in_data[BYTE_W-1:0]),
      .out_valid(pk_out_valid), .out_ready(out_ready && pk_en), .out_word(pk_word)
   );

   always_comb begin
      unique case (mode)
         MODE_SPLIT: begin
            in_ready  = sp_in_ready;
            out_valid = sp_out_valid;
            out_data  = {{BYTE_W{1'b0}}, sp_byte};
         end
         MODE_PACK: begin
            in_ready  = pk_in_ready;
            out_valid = pk_out_valid;
            out_data  = pk_word;
         end
         MODE_BYTE_BYTE: begin
            in_ready  = out_ready;
            out_valid = in_valid;
            out_data  = {{BYTE_W{1'b0}}, in_data[BYTE_W-1:0]};
         end
         default: begin
            in_ready  = out_ready;
            out_valid = in_valid;
            out_data  = in_data;
         end
      endcase
   end

   // R3: narrow read carries nothing in the upper half
   assert_narrow_upper_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && (mode == MODE_BYTE_BYTE || mode == MODE_SPLIT))
      |-> (out_data[WORD_W-1:BYTE_W] == '0));
   // R10: conversion modes start empty
   assert_empty_after_reset_R10: assert property (@(posedge clk)
      (!rst_n) |=> (!sp_out_valid && !pk_out_valid));
endmodule

// File: tb/sim_bus_width_matcher.sv
module sim_bus_width_matcher;
   logic        clk = 0;
   logic        rst_n = 0;
   logic        cfg_wr_narrow = 0, cfg_rd_narrow = 0, cfg_big_n = 0;
   logic        in_valid = 0, out_ready = 0;
   logic [17:0] in_data = '0;
   logic        in_ready, out_valid;
   logic [17:0] out_data;
   int          n_run = 0, n_fail = 0;

   always #10 clk = ~clk;

   bus_width_matcher u0 (
      .clk(clk), .rst_n(rst_n), .cfg_wr_narrow(cfg_wr_narrow),
      .cfg_rd_narrow(cfg_rd_narrow), .cfg_big_n(cfg_big_n),
      .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
      .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data)
   );

   task automatic check(string req, logic [17:0] act, logic [17:0] exp);
      n_run++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   // reset with config, then flip config pins (must be ignored, R1)
   task automatic do_reset(logic wn, logic rn, logic bn);
      @(negedge clk);
      rst_n = 0; in_valid = 0; out_ready = 0;
      cfg_wr_narrow = wn; cfg_rd_narrow = rn; cfg_big_n = bn;
      repeat (2) @(negedge clk);
      rst_n = 1;
      @(negedge clk);
      cfg_wr_narrow = ~wn; cfg_rd_narrow = ~rn; cfg_big_n = ~bn;
   endtask

   task automatic push(logic [17:0] d);
      @(negedge clk);
      in_valid = 1; in_data = d; #1;
      while (!in_ready) begin @(negedge clk); #1; end
      @(posedge clk); #1;
      in_valid = 0;
   endtask

   task automatic pop(string req, logic [17:0] exp);
      @(negedge clk);
      out_ready = 1; #1;
      while (!out_valid) begin @(negedge clk); #1; end
      check(req, out_data, exp);
      @(posedge clk); #1;
      out_ready = 0;
   endtask

   task automatic t_long_long;
      do_reset(0, 0, 0);
      @(negedge clk);
      out_ready = 1; in_valid = 1; in_data = 18'h2A5C3; #1;
      check("R2 data", out_data, 18'h2A5C3);
      check("R2 valid", {17'b0, out_valid}, 18'd1);
      check("R1 mode kept after pin change", out_data, 18'h2A5C3);
      out_ready = 0; #1;
      check("R2 ready", {17'b0, in_ready}, 18'd0);
      in_valid = 0;
   endtask

   task automatic t_byte_byte;
      do_reset(1, 1, 0);
      @(negedge clk);
      out_ready = 1; in_valid = 1; in_data = 18'h3FFAB; #1;
      check("R3 byte", out_data, 18'h001AB);
      in_valid = 0; out_ready = 0;
   endtask

   task automatic t_split(logic bn);
      do_reset(0, 1, bn);
      #1;
      check("R10 out_valid", {17'b0, out_valid}, 18'd0);
      check("R10 in_ready", {17'b0, in_ready}, 18'd1);
      push(18'h1F0A5);   // hi=0F8, lo=0A5
      @(negedge clk); #1;
      check("R11 valid next", {17'b0, out_valid}, 18'd1);
      check("R11 blocked", {17'b0, in_ready}, 18'd0);
      if (!bn) begin
         // R8 stall
         repeat (2) @(negedge clk);
         #1 check("R8 split stable", out_data, 18'h000F8);
         pop("R4 first", 18'h000F8);
         pop("R4 second", 18'h000A5);
      end else begin
         pop("R5 first", 18'h000A5);
         pop("R5 second", 18'h000F8);
      end
      @(negedge clk); #1;
      check("R11 drained", {17'b0, out_valid}, 18'd0);
   endtask

   task automatic t_pack(logic bn);
      do_reset(1, 0, bn);
      #1 check("R10 pack empty", {17'b0, out_valid}, 18'd0);
      push(18'h00123);
      push(18'h3FE45);   // only low 9 bits: 045
      if (!bn) begin
         repeat (2) @(negedge clk);
         #1 check("R8 pack stable", out_data, {9'h123, 9'h045});
         pop("R6 word", {9'h123, 9'h045});
      end else begin
         pop("R7 word", {9'h045, 9'h123});
      end
   endtask

   task automatic t_pack_discard;
      do_reset(1, 0, 0);
      push(18'h00111);
      do_reset(1, 0, 0);
      push(18'h00077);
      push(18'h00188);
      pop("R9 fresh pair", {9'h077, 9'h188});
   endtask

   initial begin
      t_long_long();
      t_byte_byte();
      t_split(0);
      t_split(1);
      t_pack(0);
      t_pack(1);
      t_pack_discard();
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      n_run++; n_fail++;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end
endmodule